// File: doc/BRIEF.md
# Keyed Watchdog Timer

This block is a hardware watchdog built around an 8-bit down-counter. Software controls it with one kind of register write. Each write carries three things: a count, a command and a 7-bit key. The command either starts the watchdog or stops it. A start while the watchdog is already counting reloads the count, which is how software restarts the countdown.

A write is accepted only when its key is the bitwise inverse of the last accepted key. This protects the watchdog against a runaway program that keeps repeating one store.

While running, the counter steps down once per slow tick. The tick comes from a prescaler that divides the system clock by a parameter. The default of 131072 gives about 763 Hz from 100 MHz. When the count reaches one, the block raises a non-maskable interrupt request, so software gets one last chance to act. When the count reaches zero, the block emits a chip reset pulse.

Top module: `keyed_watchdog`

## Requirements
- R1: After reset the watchdog is stopped, with the count at 0 and both `nmi_o` and `reset_o` low. They stay that way until a write is accepted, however many ticks elapse.
- R2: A write is accepted only if `wr_key` equals the stored key XOR 7'h7F. The stored key starts at parameter KEY_INIT (default 7'h15). On acceptance, the stored key becomes `wr_key`.
- R3: A write with a non-matching key is ignored entirely. The count, the running state, `nmi_o` and the stored key are all left as they were.
- R4: An accepted write with `wr_cmd`=1 (start) loads `wr_count` into the counter and starts it. This applies even when the counter is already running, which restarts the countdown from the new value. The loaded value appears on `count_o` in the cycle after the write.
- R5: While running, the count drops by exactly one every DIV clock cycles. The first decrement lands DIV cycles after the accepting clock edge.
- R6: An accepted write with `wr_cmd`=0 (stop) halts the counter. The count keeps its value, no further decrement or reset occurs, and `nmi_o` is cleared.
- R7: `nmi_o` rises in the same cycle that the count becomes 1, whether by decrement or by a start load. It then stays high until the next accepted write.
- R8: When a tick finds the count at 1 or 0, three things happen:
  - the count becomes 0;
  - the watchdog stops;
  - `reset_o` goes high for exactly RST_CYCLES cycles, and `nmi_o` is high as well.

  Starting with a count of 0 therefore causes a reset on the first tick.
- R9: When an accepted write and a tick fall in the same cycle, the write takes effect and the tick is discarded. The prescaler also restarts its period.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| wr_en | input | 1 | Control write strobe, one cycle per write |
| wr_key | input | KEY_W | Key presented with the write |
| wr_cmd | input | 1 | 1 = start/reload, 0 = stop |
| wr_count | input | CNT_W | Start value for the counter |
| count_o | output | CNT_W | Current counter value |
| nmi_o | output | 1 | Non-maskable interrupt request |
| reset_o | output | 1 | Chip reset request pulse |

## Verification
A corrupted stored key shows up as soon as the next write. A correct write is refused, and the refusal is visible on `count_o` one cycle later. A wrong key that gets accepted changes the count, which is visible just as early.

A prescaler error moves every decrement away from its DIV-cycle grid. It is caught at the first tick after a write. Wrong stop, NMI or reset-pulse state shows within one tick period as:
- a count that keeps moving after a stop;
- a missing or late `nmi_o`;
- a `reset_o` pulse of the wrong width.

// File: rtl/wdg_pkg.sv
package wdg_pkg;
  localparam int unsigned KEY_W_DEF = 7;
  localparam int unsigned CNT_W_DEF = 8;

  typedef enum logic {
    CMD_STOP  = 1'b0,
    CMD_START = 1'b1
  } wdg_cmd_e;

  function automatic logic [KEY_W_DEF-1:0] key_flip(input logic [KEY_W_DEF-1:0] k);
    return k ^ {KEY_W_DEF{1'b1}};
  endfunction
endpackage

// File: rtl/wdg_keygate.sv
module wdg_keygate #(
  parameter int unsigned KEY_W = 7,
  parameter logic [KEY_W-1:0] KEY_INIT = 7'h15
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             wr_en,
  input  logic [KEY_W-1:0] wr_key,
  output logic             accept
);
  logic [KEY_W-1:0] key_q;
  logic [KEY_W-1:0] key_d;
  logic [KEY_W-1:0] want;

  always_comb begin
    want   = ~key_q;
    accept = wr_en && (wr_key == want);
    key_d  = key_q;
    if (accept) key_d = wr_key;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) key_q <= KEY_INIT;
    else        key_q <= key_d;
  end

  AST_KEY_CHAIN: assert property (@(posedge clk) disable iff (!rst_n)
    accept |=> (key_q == ($past(key_q) ^ {KEY_W{1'b1}}))); // R2
  AST_KEY_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    !accept |=> $stable(key_q)); // R3
endmodule

// File: rtl/wdg_prescale.sv
module wdg_prescale #(
  parameter int unsigned DIV = 131072
) (
  input  logic clk,
  input  logic rst_n,
  input  logic run,
  input  logic clr,
  output logic tick
);
  localparam int unsigned PW = (DIV > 1) ? $clog2(DIV) : 1;
  localparam logic [PW-1:0] LAST = PW'(DIV - 1);

  generate
    if (DIV > 1) begin : g_div
      logic [PW-1:0] pre_q;
      logic [PW-1:0] pre_d;
      logic          pre_en;

      always_comb begin
        pre_en = 1'b1;
        pre_d  = pre_q + 1'b1;
        if (clr || !run)          pre_d = '0;
        else if (pre_q == LAST)   pre_d = '0;
      end

      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)      pre_q <= '0;
        else if (pre_en) pre_q <= pre_d;
      end

      assign tick = run && !clr && (pre_q == LAST);

      AST_TICK_GAP: assert property (@(posedge clk) disable iff (!rst_n)
        tick |=> !tick); // R5
    end else begin : g_nodiv
      assign tick = run && !clr;
    end
  endgenerate
endmodule

// File: rtl/wdg_countdown.sv
module wdg_countdown #(
  parameter int unsigned CNT_W = 8
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             accept,
  input  logic             cmd_start,
  input  logic [CNT_W-1:0] wr_count,
  input  logic             tick,
  output logic             run,
  output logic             bite,
  output logic             nmi,
  output logic [CNT_W-1:0] count
);
  localparam logic [CNT_W-1:0] ONE = CNT_W'(1);
  localparam logic [CNT_W-1:0] TWO = CNT_W'(2);

  logic [CNT_W-1:0] cnt_q, cnt_d;
  logic             run_q, run_d;
  logic             nmi_q, nmi_d;
  logic             bite_c;

  always_comb begin
    cnt_d  = cnt_q;
    run_d  = run_q;
    nmi_d  = nmi_q;
    bite_c = 1'b0;
    if (accept) begin
      if (cmd_start) begin
        cnt_d = wr_count;
        run_d = 1'b1;
        nmi_d = (wr_count == ONE);
      end else begin
        run_d = 1'b0;
        nmi_d = 1'b0;
      end
    end else if (run_q && tick) begin
      if (cnt_q <= ONE) begin
        cnt_d  = '0;
        run_d  = 1'b0;
        nmi_d  = 1'b1;
        bite_c = 1'b1;
      end else begin
        cnt_d = cnt_q - ONE;
        if (cnt_q == TWO) nmi_d = 1'b1;
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt_q <= '0;
      run_q <= 1'b0;
      nmi_q <= 1'b0;
    end else begin
      cnt_q <= cnt_d;
      run_q <= run_d;
      nmi_q <= nmi_d;
    end
  end

  assign run   = run_q;
  assign bite  = bite_c;
  assign nmi   = nmi_q;
  assign count = cnt_q;

  AST_DEC_ONE: assert property (@(posedge clk) disable iff (!rst_n)
    (run_q && tick && !accept && cnt_q > ONE) |=> (cnt_q == $past(cnt_q) - ONE)); // R5
  AST_STOP_FREEZE: assert property (@(posedge clk) disable iff (!rst_n)
    (!run_q && !accept) |=> $stable(cnt_q)); // R6
  AST_NMI_HELD: assert property (@(posedge clk) disable iff (!rst_n)
    (nmi_q && !accept) |=> nmi_q); // R7
  AST_LOAD: assert property (@(posedge clk) disable iff (!rst_n)
    (accept && cmd_start) |=> (cnt_q == $past(wr_count) && run_q)); // R4
endmodule

// File: rtl/wdg_pulse.sv
module wdg_pulse #(
  parameter int unsigned RST_CYCLES = 16
) (
  input  logic clk,
  input  logic rst_n,
  input  logic fire,
  output logic pulse
);
  localparam int unsigned CW = $clog2(RST_CYCLES + 1);
  localparam logic [CW-1:0] LEN = CW'(RST_CYCLES);

  logic [CW-1:0] left_q, left_d;
  logic          left_en;

  always_comb begin
    left_en = fire || (left_q != '0);
    left_d  = fire ? LEN : left_q - 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)       left_q <= '0;
    else if (left_en) left_q <= left_d;
  end

  assign pulse = (left_q != '0);

  AST_PULSE_START: assert property (@(posedge clk) disable iff (!rst_n)
    fire |=> pulse); // R8
endmodule

// File: rtl/keyed_watchdog.sv
module keyed_watchdog #(
  parameter int unsigned KEY_W      = wdg_pkg::KEY_W_DEF,
  parameter int unsigned CNT_W      = wdg_pkg::CNT_W_DEF,
  parameter int unsigned DIV        = 131072,
  parameter int unsigned RST_CYCLES = 16,
  parameter logic [KEY_W-1:0] KEY_INIT = 7'h15
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             wr_en,
  input  logic [KEY_W-1:0] wr_key,
  input  logic             wr_cmd,
  input  logic [CNT_W-1:0] wr_count,
  output logic [CNT_W-1:0] count_o,
  output logic             nmi_o,
  output logic             reset_o
);
  import wdg_pkg::*;

  logic [1:0] sync_q;
  logic       rst_s_n;
  logic       accept;
  logic       tick;
  logic       run;
  logic       bite;
  logic       cmd_start;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) sync_q <= 2'b00;
    else        sync_q <= {sync_q[0], 1'b1};
  end
  assign rst_s_n   = sync_q[1];
  assign cmd_start = (wdg_cmd_e'(wr_cmd) == CMD_START);

  wdg_keygate #(.KEY_W(KEY_W), .KEY_INIT(KEY_INIT)) u_key (
    .clk(clk), .rst_n(rst_s_n), .wr_en(wr_en), .wr_key(wr_key), .accept(accept)
  );

  wdg_prescale #(.DIV(DIV)) u_pre (
    .clk(clk), .rst_n(rst_s_n), .run(run), .clr(accept), .tick(tick)
  );

  wdg_countdown #(.CNT_W(CNT_W)) u_cnt (
    .clk(clk), .rst_n(rst_s_n), .accept(accept), .cmd_start(cmd_start),
    .wr_count(wr_count), .tick(tick), .run(run), .bite(bite),
    .nmi(nmi_o), .count(count_o)
  );

  wdg_pulse #(.RST_CYCLES(RST_CYCLES)) u_pulse (
    .clk(clk), .rst_n(rst_s_n), .fire(bite), .pulse(reset_o)
  );

  AST_BITE_WITH_NMI: assert property (@(posedge clk) disable iff (!rst_s_n)
    $rose(reset_o) |-> (nmi_o && count_o == '0)); // R8
  AST_IDLE_QUIET: assert property (@(posedge clk) disable iff (!rst_s_n)
    (!run && !accept && !reset_o) |=> !$rose(reset_o)); // R1
  AST_WRITE_WINS: assert property (@(posedge clk) disable iff (!rst_s_n)
    accept |=> !reset_o || $past(reset_o)); // R9
endmodule

// File: tb/keyed_watchdog_test.sv
module keyed_watchdog_test;
  localparam int DIV = 8;
  localparam int RST = 3;

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       wr_en = 1'b0;
  logic [6:0] wr_key = '0;
  logic       wr_cmd = 1'b0;
  logic [7:0] wr_count = '0;
  logic [7:0] count_o;
  logic       nmi_o;
  logic       reset_o;

  keyed_watchdog #(.DIV(DIV), .RST_CYCLES(RST), .KEY_INIT(7'h15)) uut (
    .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_key(wr_key), .wr_cmd(wr_cmd),
    .wr_count(wr_count), .count_o(count_o), .nmi_o(nmi_o), .reset_o(reset_o)
  );

  always #5 clk = ~clk;

  typedef struct {
    int         stamp;
    logic [7:0] cnt;
    logic       nmi;
    logic       rst;
    string      tag;
  } exp_t;

  exp_t q[$];
  int   cyc = 0;
  int   checks = 0;
  int   errors = 0;
  bit   done = 0;

  always @(posedge clk) cyc <= cyc + 1;

  task automatic expect_at(input int st, input logic [7:0] c, input logic n,
                           input logic r, input string tag);
    exp_t it;
    it.stamp = st; it.cnt = c; it.nmi = n; it.rst = r; it.tag = tag;
    q.push_back(it);
  endtask

  // Monitor: compares the outputs at the falling edge against queued items.
  always @(negedge clk) begin
    while (q.size() > 0 && q[0].stamp <= cyc) begin
      exp_t it;
      it = q.pop_front();
      checks++;
      if (it.stamp < cyc) begin
        errors++;
        $display("FAIL %s: item for cycle %0d missed (now %0d)", it.tag, it.stamp, cyc);
      end else if (count_o !== it.cnt || nmi_o !== it.nmi || reset_o !== it.rst) begin
        errors++;
        $display("FAIL %s @%0d: count=%0d nmi=%b rst=%b expected count=%0d nmi=%b rst=%b",
                 it.tag, cyc, count_o, nmi_o, reset_o, it.cnt, it.nmi, it.rst);
      end
    end
  end

  // Drives one write so that the accepting edge makes cyc equal e.
  task automatic wr(input logic [6:0] k, input logic c, input logic [7:0] n, output int e);
    @(negedge clk);
    e = cyc + 1;
    wr_en = 1'b1; wr_key = k; wr_cmd = c; wr_count = n;
    @(posedge clk);
    @(negedge clk);
    wr_en = 1'b0;
  endtask

  task automatic wait_to(input int n);
    while (cyc < n) @(negedge clk);
  endtask

  initial begin
    int e, r, f;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);
    // R1: stopped after reset, nothing fires
    expect_at(cyc + 1, 8'd0, 1'b0, 1'b0, "R1 reset state");
    expect_at(cyc + 3 * DIV, 8'd0, 1'b0, 1'b0, "R1 idle after ticks");
    wait_to(cyc + 3 * DIV + 1);

    // R3: wrong key (stored key itself, not its inverse) ignored
    wr(7'h15, 1'b1, 8'd5, e);
    expect_at(e + 1, 8'd0, 1'b0, 1'b0, "R3 bad key start ignored");
    expect_at(e + 2 * DIV, 8'd0, 1'b0, 1'b0, "R3 still stopped");
    wait_to(e + 2 * DIV + 1);

    // R2 R4 R5 R7 R8: full countdown to bite; key 0x6A accepted
    wr(7'h6A, 1'b1, 8'd3, e);
    expect_at(e, 8'd3, 1'b0, 1'b0, "R2 R4 valid start loads");
    expect_at(e + DIV - 1, 8'd3, 1'b0, 1'b0, "R5 before first tick");
    expect_at(e + DIV, 8'd2, 1'b0, 1'b0, "R5 first decrement");
    expect_at(e + 2 * DIV, 8'd1, 1'b1, 1'b0, "R7 nmi at one");
    expect_at(e + 3 * DIV - 1, 8'd1, 1'b1, 1'b0, "R7 nmi held");
    expect_at(e + 3 * DIV, 8'd0, 1'b1, 1'b1, "R8 reset at zero");
    expect_at(e + 3 * DIV + RST - 1, 8'd0, 1'b1, 1'b1, "R8 reset last cycle");
    expect_at(e + 3 * DIV + RST, 8'd0, 1'b1, 1'b0, "R8 reset width");
    expect_at(e + 5 * DIV, 8'd0, 1'b1, 1'b0, "R8 stopped after bite");
    wait_to(e + 5 * DIV + 1);

    // R4: restart while running reloads (key 0x15)
    wr(7'h15, 1'b1, 8'd4, e);
    expect_at(e + DIV, 8'd3, 1'b0, 1'b0, "R4 run before restart");
    wait_to(e + DIV + 1);
    r = e + 10;
    wait_to(r - 1);
    wr(7'h6A, 1'b1, 8'd6, r);
    expect_at(r, 8'd6, 1'b0, 1'b0, "R4 reload value");
    expect_at(r + DIV - 1, 8'd6, 1'b0, 1'b0, "R4 R5 reload restarts period");
    expect_at(r + DIV, 8'd5, 1'b0, 1'b0, "R5 decrement after reload");
    wait_to(r + DIV + 1);

    // R3: bad-key stop ignored; R6: valid stop freezes
    wait_to(r + 17);
    wr(7'h6A, 1'b0, 8'd0, e);
    expect_at(r + 3 * DIV, 8'd3, 1'b0, 1'b0, "R3 bad stop ignored");
    wait_to(r + 3 * DIV + 1);
    wr(7'h15, 1'b0, 8'd0, e);
    expect_at(e, 8'd3, 1'b0, 1'b0, "R6 stop keeps count");
    expect_at(e + 3 * DIV, 8'd3, 1'b0, 1'b0, "R6 frozen after stop");
    wait_to(e + 3 * DIV + 1);

    // R6 R7: stop clears nmi
    wr(7'h6A, 1'b1, 8'd2, e);
    expect_at(e + DIV, 8'd1, 1'b1, 1'b0, "R7 nmi from two");
    wait_to(e + DIV + 2);
    wr(7'h15, 1'b0, 8'd0, f);
    expect_at(f, 8'd1, 1'b0, 1'b0, "R6 R7 stop clears nmi");
    expect_at(f + 3 * DIV, 8'd1, 1'b0, 1'b0, "R6 no reset after stop");
    wait_to(f + 3 * DIV + 1);

    // R7: load of one raises nmi immediately; restart clears it
    wr(7'h6A, 1'b1, 8'd1, f);
    expect_at(f, 8'd1, 1'b1, 1'b0, "R7 nmi on load of one");
    wait_to(f + 1);
    wr(7'h15, 1'b1, 8'd5, f);
    expect_at(f, 8'd5, 1'b0, 1'b0, "R7 restart clears nmi");
    wait_to(f + 1);
    wr(7'h6A, 1'b0, 8'd0, f);
    expect_at(f, 8'd5, 1'b0, 1'b0, "R6 stop again");
    wait_to(f + 1);

    // R8: start with zero bites on first tick
    wr(7'h15, 1'b1, 8'd0, e);
    expect_at(e, 8'd0, 1'b0, 1'b0, "R8 zero load");
    expect_at(e + DIV, 8'd0, 1'b1, 1'b1, "R8 zero bites on first tick");
    expect_at(e + DIV + RST, 8'd0, 1'b1, 1'b0, "R8 zero bite width");
    wait_to(e + DIV + RST + 1);

    // R9: write on the tick edge wins
    wr(7'h6A, 1'b1, 8'd9, e);
    wait_to(e + DIV - 2);
    wr(7'h15, 1'b1, 8'd9, f);
    expect_at(f, 8'd9, 1'b0, 1'b0, "R9 tick discarded");
    expect_at(f + DIV - 1, 8'd9, 1'b0, 1'b0, "R9 period restarted");
    expect_at(f + DIV, 8'd8, 1'b0, 1'b0, "R9 next decrement");
    if (f != e + DIV) begin
      checks++; errors++;
      $display("FAIL R9: write edge %0d expected %0d", f, e + DIV);
    end
    wait_to(f + DIV + 2);

    done = 1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      checks++; errors++;
      $display("FAIL watchdog: bench timed out");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end
endmodule